// File: doc/BRIEF.md
# Clock-Recovery Loop Filter and Fine-Tune Counter

This block sits between a multi-region phase detector and a digitally controlled oscillator in an all-digital clock-recovery loop. Once per bit period the detector hands it one sample: three early flags, three late flags and a centre-hit flag. The block turns each sample into a signed 4-bit phase code and sums the codes over a fixed window of accepted samples. At the end of each window it takes the window average, smooths it with a two-tap low-pass filter, and applies a dead-band to the result. It then issues a direction bit and a one-cycle count-enable to a saturating 4-bit counter. The counter's value is the oscillator fine-tune code.

A lock flag rises after a run of windows in which the centre-hit flag dominated and no correction was needed. The flag drops on the first window that makes a correction.

The sample input is a valid/ready stream. The block never applies back-pressure. Ready is high in every cycle outside reset, so a sample is consumed in each cycle in which valid is high. Cycles with valid low do not advance the window. The tune code, direction, count-enable and lock flag are plain level outputs.

Top module: `cdr_loop_ctrl`

## Requirements
- R1: Each accepted sample becomes code = (up[0]·1 + up[1]·2 + up[2]·4) − (dn[0]·1 + dn[1]·2 + dn[2]·4), held as 4-bit two's complement. The centre flag adds nothing to the code.
- R2: A window closes on its WIN-th accepted sample (WIN = 8). Cycles with in_valid low change neither the window contents nor its position.
- R3: At window close, avg = floor(window sum / WIN). The filter state becomes F = floor((F_prev + avg) / 2), with F starting at 0 after reset.
- R4: At the clock edge that closes a window, udn is set to 1 if the new F > 0 and to 0 otherwise. In the same edge, cck is set high for exactly one cycle if |F| ≥ DEAD (DEAD = 2); otherwise cck stays low.
- R5: ft changes only on the edge that follows a cycle with cck high. It moves by one: upward when udn = 1, downward when udn = 0.
- R6: ft saturates: it stays at 15 when asked to go up and at 0 when asked to go down.
- R7: A window is centre-dominated when twice its count of centre hits is at least WIN. locked rises at the close of the 4th consecutive centre-dominated window that makes no correction.
- R8: A window that makes a correction (cck set) clears locked and restarts the run in the same edge. A window that is neither dominated nor correcting restarts the run but leaves locked unchanged.
- R9: A synchronous active-high reset sets ft to 8 and clears udn, cck, locked, the filter state, the run count and the window contents.
- R10: in_ready is high in every cycle with rst low and low while rst is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Detector sample valid |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| pd_up | input | 3 | Early flags, weights 1, 2, 4 on bits 0, 1, 2 |
| pd_dn | input | 3 | Late flags, weights 1, 2, 4 on bits 0, 1, 2 |
| pd_lc | input | 1 | Centre-region hit |
| udn | output | 1 | Direction: 1 = count up |
| cck | output | 1 | One-cycle count enable |
| ft | output | 4 | Oscillator fine-tune code |
| locked | output | 1 | Loop lock indicator |

## Verification
The bench builds the block with its default parameters: an 8-sample window, a dead-band of 2, a 4-window lock run and a 4-bit code. These values let a few dozen windows drive ft from its mid value to both rails. They also reach the filter's fixed point inside the dead-band, where the lock run can complete, and a single correcting window that tears the lock down. A random stream with idle gaps and multi-flag samples exercises the window count and the floor rounding of negative sums on every clock, checked against the bench's reference model.

// File: rtl/cdr_loop_pkg.sv
package cdr_loop_pkg;
  typedef logic signed [3:0] pd_code_t;

  function automatic pd_code_t pd_to_code(input logic [2:0] up, input logic [2:0] dn);
    logic [3:0] u;
    logic [3:0] d;
    u = {1'b0, up};
    d = {1'b0, dn};
    return pd_code_t'(u - d);
  endfunction
endpackage

// File: rtl/cdr_window_acc.sv
module cdr_window_acc #(
  parameter int WIN   = 8,
  parameter int SUM_W = 8,
  parameter int CW    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  cdr_loop_pkg::pd_code_t  code,
  input  logic                    lc,
  output logic                    done,
  output logic signed [SUM_W-1:0] win_sum,
  output logic [CW-1:0]           win_lc
);
  localparam int LW = $clog2(WIN);

  logic [LW-1:0]           cnt;
  logic signed [SUM_W-1:0] acc;
  logic [CW-1:0]           lcc;

  assign done    = fire && (cnt == LW'(WIN - 1));
  assign win_sum = acc + SUM_W'(code);
  assign win_lc  = lcc + CW'(lc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
      lcc <= '0;
    end else if (fire) begin
      if (done) begin
        cnt <= '0;
        acc <= '0;
        lcc <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= win_sum;
        lcc <= win_lc;
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(cnt) && $stable(acc) && $stable(lcc)));
  assert_close_clears_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt == '0 && acc == '0));
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
  parameter int WIN   = 8,
  parameter int SUM_W = 8,
  parameter int DEAD  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    done,
  input  logic signed [SUM_W-1:0] win_sum,
  output logic                    step,
  output logic                    udn,
  output logic                    cck
);
  localparam int LW = $clog2(WIN);
  localparam int FW = 5;
  localparam logic signed [FW-1:0] DB_P = FW'(DEAD);
  localparam logic signed [FW-1:0] DB_N = -DB_P;

  logic signed [FW-1:0] filt;
  logic signed [FW-1:0] avg;
  logic signed [FW:0]   tot;
  logic signed [FW-1:0] f_nx;

  always_comb begin
    avg  = FW'(win_sum >>> LW);
    tot  = {filt[FW-1], filt} + {avg[FW-1], avg};
    f_nx = FW'(tot >>> 1);
    step = done && ((f_nx >= DB_P) || (f_nx <= DB_N));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= '0;
      udn  <= 1'b0;
      cck  <= 1'b0;
    end else begin
      cck <= step;
      if (done) begin
        filt <= f_nx;
        udn  <= (f_nx > 0);
      end
    end
  end

  assert_cck_single_R4: assert property (@(posedge clk) disable iff (rst)
    cck |=> !cck);
  assert_cck_from_close_R4: assert property (@(posedge clk) disable iff (rst)
    cck |-> $past(done));
  assert_udn_at_close_R4: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(udn));
endmodule

// File: rtl/cdr_tune_counter.sv
module cdr_tune_counter #(
  parameter int FTW     = 4,
  parameter int FT_INIT = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_en,
  input  logic           up_dir,
  output logic [FTW-1:0] ft
);
  localparam logic [FTW-1:0] FT_MAX = '1;
  localparam logic [FTW-1:0] FT_MIN = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ft <= FTW'(FT_INIT);
    end else if (cnt_en) begin
      if (up_dir && ft != FT_MAX) ft <= ft + 1'b1;
      else if (!up_dir && ft != FT_MIN) ft <= ft - 1'b1;
    end
  end

  assert_hold_no_enable_R5: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(ft));
  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_dir && ft != FT_MAX) |=> ft == $past(ft) + 1'b1);
  assert_sat_top_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_dir && ft == FT_MAX) |=> ft == FT_MAX);
  assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !up_dir && ft == FT_MIN) |=> ft == FT_MIN);
endmodule

// File: rtl/cdr_lock_qual.sv
module cdr_lock_qual #(
  parameter int WIN       = 8,
  parameter int CW        = 4,
  parameter int LOCK_WINS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          step,
  input  logic [CW-1:0] win_lc,
  output logic          locked
);
  localparam int SW = $clog2(LOCK_WINS + 1);

  logic [SW-1:0] streak;
  logic [SW-1:0] streak_nx;
  logic [CW:0]   twice;
  logic          dominated;

  always_comb begin
    twice     = {win_lc, 1'b0};
    dominated = twice >= (CW + 1)'(WIN);
    streak_nx = (streak == SW'(LOCK_WINS)) ? streak : streak + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      streak <= '0;
      locked <= 1'b0;
    end else if (done) begin
      if (step) begin
        streak <= '0;
        locked <= 1'b0;
      end else if (dominated) begin
        streak <= streak_nx;
        if (streak_nx == SW'(LOCK_WINS)) locked <= 1'b1;
      end else begin
        streak <= '0;
      end
    end
  end

  assert_clear_on_step_R8: assert property (@(posedge clk) disable iff (rst)
    (done && step) |=> !locked);
  assert_rise_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(done) && !$past(step)));
endmodule

// File: rtl/cdr_loop_ctrl.sv
module cdr_loop_ctrl #(
  parameter int WIN       = 8,
  parameter int DEAD      = 2,
  parameter int LOCK_WINS = 4,
  parameter int FTW       = 4,
  parameter int FT_INIT   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     pd_up,
  input  logic [2:0]     pd_dn,
  input  logic           pd_lc,
  output logic           udn,
  output logic           cck,
  output logic [FTW-1:0] ft,
  output logic           locked
);
  import cdr_loop_pkg::*;

  localparam int SUM_W = $clog2(WIN * 7 + 1) + 2;
  localparam int CW    = $clog2(WIN + 1);

  logic                    fire;
  pd_code_t                code;
  logic                    done;
  logic signed [SUM_W-1:0] win_sum;
  logic [CW-1:0]           win_lc;
  logic                    step;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;
  assign code     = pd_to_code(pd_up, pd_dn);

  cdr_window_acc #(.WIN(WIN), .SUM_W(SUM_W), .CW(CW)) u_acc (
    .clk(clk), .rst(rst), .fire(fire), .code(code), .lc(pd_lc),
    .done(done), .win_sum(win_sum), .win_lc(win_lc)
  );

  cdr_loop_filter #(.WIN(WIN), .SUM_W(SUM_W), .DEAD(DEAD)) u_filt (
    .clk(clk), .rst(rst), .done(done), .win_sum(win_sum),
    .step(step), .udn(udn), .cck(cck)
  );

  cdr_tune_counter #(.FTW(FTW), .FT_INIT(FT_INIT)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cck), .up_dir(udn), .ft(ft)
  );

  cdr_lock_qual #(.WIN(WIN), .CW(CW), .LOCK_WINS(LOCK_WINS)) u_lock (
    .clk(clk), .rst(rst), .done(done), .step(step), .win_lc(win_lc),
    .locked(locked)
  );
endmodule

// File: tb/cdr_loop_ctrl_bench.sv
module cdr_loop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 8;
  localparam int DEAD = 2;
  localparam int LOCKN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] pd_up = '0;
  logic [2:0] pd_dn = '0;
  logic pd_lc = 1'b0;
  logic in_ready, udn, cck, locked;
  logic [3:0] ft;

  int n_tests = 0;
  int n_fail = 0;
  bit started = 0;

  int m_cnt, m_sum, m_lc, m_filt, m_streak;
  bit m_udn, m_cck, m_lock;
  int m_ft;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cdr_loop_ctrl u_cdr_loop_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .pd_up(pd_up), .pd_dn(pd_dn), .pd_lc(pd_lc),
    .udn(udn), .cck(cck), .ft(ft), .locked(locked)
  );

  function automatic int fdiv(int a, int b);
    int q;
    q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated at every rising edge
  always @(posedge clk) begin
    int code, s, l, f;
    started = 1;
    if (rst) begin
      m_cnt = 0; m_sum = 0; m_lc = 0; m_filt = 0; m_streak = 0;
      m_udn = 0; m_cck = 0; m_lock = 0; m_ft = 8;
    end else begin
      if (m_cck) begin
        if (m_udn && m_ft < 15) m_ft++;
        else if (!m_udn && m_ft > 0) m_ft--;
      end
      m_cck = 0;
      if (in_valid) begin
        code = (pd_up[0] ? 1 : 0) + (pd_up[1] ? 2 : 0) + (pd_up[2] ? 4 : 0)
             - (pd_dn[0] ? 1 : 0) - (pd_dn[1] ? 2 : 0) - (pd_dn[2] ? 4 : 0);
        s = m_sum + code;
        l = m_lc + (pd_lc ? 1 : 0);
        if (m_cnt == WIN - 1) begin
          f = fdiv(m_filt + fdiv(s, WIN), 2);
          m_filt = f;
          m_udn = (f > 0);
          m_cck = (f >= DEAD) || (f <= -DEAD);
          if (m_cck) begin
            m_lock = 0; m_streak = 0;
          end else if (2 * l >= WIN) begin
            if (m_streak < LOCKN) m_streak++;
            if (m_streak == LOCKN) m_lock = 1;
          end else begin
            m_streak = 0;
          end
          m_cnt = 0; m_sum = 0; m_lc = 0;
        end else begin
          m_cnt++; m_sum = s; m_lc = l;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R10 in_ready", in_ready, rst ? 0 : 1);
      chk("R5/R6 ft", ft, m_ft);
      chk("R4 cck", cck, m_cck);
      chk("R4 udn", udn, m_udn);
      chk("R7/R8 locked", locked, m_lock);
    end
  end

  task automatic push(int u, int d, int l, bit v);
    @(negedge clk);
    #1;
    in_valid = v;
    pd_up = 3'(u);
    pd_dn = 3'(d);
    pd_lc = l[0];
  endtask

  task automatic window(int u, int d, int l, bit gaps);
    for (int i = 0; i < WIN; i++) begin
      push(u, d, l, 1'b1);
      if (gaps && (i % 3 == 1)) push(7, 7, 1, 1'b0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) push(0, 0, 0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    // R9: reset state
    @(negedge clk); #2;
    chk("R9 ft reset", ft, 8);
    chk("R9 locked reset", locked, 0);
    chk("R9 cck reset", cck, 0);
    chk("R10 ready in reset", in_ready, 0);
    push(0, 0, 0, 1'b0);
    rst = 1'b0;
    idle(2);
    // R1/R3: all weight-1 early codes, average 1, filtered 0 -> no step
    window(1, 0, 0, 1'b0);
    idle(3);
    chk("R3 small window no step ft", ft, 8);
    // R2: idle cycles with garbage do not count
    window(4, 0, 0, 1'b1);
    idle(3);
    chk("R2 gapped window steps up once ft", ft, 9);
    // R6: drive to top rail
    for (int w = 0; w < 10; w++) window(4, 0, 0, 1'b0);
    idle(3);
    chk("R6 saturate high ft", ft, 15);
    // R6: drive to bottom rail
    for (int w = 0; w < 20; w++) window(0, 4, 0, 1'b0);
    idle(3);
    chk("R6 saturate low ft", ft, 0);
    // R7: centre-dominated quiet windows
    for (int w = 0; w < 6; w++) window(0, 0, 1, 1'b0);
    idle(3);
    chk("R7 lock after quiet run", locked, 1);
    // R8: correcting window drops lock
    window(4, 0, 0, 1'b0);
    idle(2);
    chk("R8 no step yet keeps lock", locked, 1);
    window(4, 0, 0, 1'b0);
    idle(3);
    chk("R8 step clears lock", locked, 0);
    chk("R5 step up from rail ft", ft, 1);
    // R1 mixes with multi-flag samples and random gaps
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push(int'(lf[2:0]), int'(lf[5:3]), int'(lf[6]), lf[9] | lf[8]);
    end
    idle(3);
    // reset mid-run
    rst = 1'b1;
    push(7, 0, 1, 1'b1);
    rst = 1'b0;
    push(0, 0, 0, 1'b0);
    #2;
    chk("R9 reset restores ft", ft, 8);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule